// File: doc/BRIEF.md
# Parallel LCD Bus Cycle Generator

This block produces single bus cycles in the 8080 style for an external display controller. It drives an active-low chip select, an active-low write strobe, an active-low read strobe, a data/command select line and a 16-bit data bus with an output enable. Of the data bus, only the low byte is used when the 8-bit width is chosen. A small register port sets the width, the tick divider and the edge times of every strobe. Writing the command or parameter register starts one write cycle. Writing the read register starts one read cycle, and the value captured on the bus can then be read back from that same register.

Every edge time is counted in ticks. A tick lasts one or two clocks. A cycle begins at tick 0 and the block is busy for all of its ticks. The timing registers, width and divider are copied when a cycle starts, so a cycle always runs with one consistent setting. One request can wait behind the running cycle. A separate push input lets a pixel source issue data-level write cycles through the same slot.

Top module: `lcdb_bus_gen`

## Requirements
- R1: After reset, chip select and both strobes are high, the output enable is low, the data/command line is high, busy is low and req_ready is high. Register 0 reads 0x13, register 1 reads 0x0C228941 and register 2 reads 0x02004618.
- R2: Register 1 (edge word) holds the following fields, and reads back the written value with bits 31:30 as zero:
  - chip-select on in bits 3:0 and chip-select off in bits 9:4;
  - write-strobe on in bits 13:10 and write-strobe off in bits 19:14;
  - read-strobe on in bits 23:20 and read-strobe off in bits 29:24.
- R3: Register 2 (cycle word) holds the write length in bits 5:0, the read length in bits 11:6, the minimum chip-select pulse in bits 17:12 and the sample tick in bits 27:22. Every other bit reads as zero.
- R4: Bit 4 of register 0 selects a tick of two clocks when it is 1 and a tick of one clock when it is 0. Every tick count below is multiplied by this tick length D.
- R5: A write to register 3 starts a write cycle with the data/command line low. A write to register 4 starts a write cycle with the line high. The written data is driven on the bus with the output enable high.
- R6: Busy rises one clock after a request is accepted. Let clock 0 be the first busy clock. Then the write strobe is low from clock we_on*D+1 for (we_off-we_on)*D clocks.
- R7: Chip select is low from clock cs_on*D+1 until tick end = max(cs_off, cs_on+cs_min). Busy lasts max(length, end)*D clocks, where length is the write or read length of the cycle. The cycle never lasts less than one tick.
- R8: A write to register 5 starts a read cycle in which the read strobe is low from clock re_on*D+1 for (re_off-re_on)*D clocks. The output enable stays low. The bus value present in clock sample_tick*D is captured, and a read of register 5 returns it.
- R9: Bits 1:0 of register 0 set the bus width: 3 selects 16 bits and any other value selects 8 bits. In 8-bit mode the driven data and the captured data keep only bits 7:0, and the upper bits are zero.
- R10: A request that arrives while a cycle runs waits in a one-entry slot and starts after the running cycle ends, with busy low for one clock between the two cycles. While the slot is full, req_ready is low and any further request is ignored.
- R11: When push_valid is high and push_ready is high, a data-level write cycle carrying push_data is queued. A register write in the same clock has priority, and push_ready is low in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next clock |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| push_valid | input | 1 | Pixel word offered for a data write cycle |
| push_data | input | 16 | Pixel word |
| push_ready | output | 1 | Pixel word accepted this clock |
| req_ready | output | 1 | Request slot is free |
| busy | output | 1 | A bus cycle is running |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_we_n | output | 1 | Write strobe, active low |
| lcd_re_n | output | 1 | Read strobe, active low |
| lcd_dc | output | 1 | Data/command select, low for command |
| lcd_dout | output | 16 | Bus data driven out |
| lcd_doe | output | 1 | Bus output enable |
| lcd_din | input | 16 | Bus data read in |

## Verification
The bench builds the block with its default reset timing parameters. These give a two-clock tick and fields wide enough that the default write cycle runs 48 clocks, so the stretched tick is exercised straight out of reset. Reprogramming covers the remaining cases: the one-clock tick, a chip-select pulse floor that lengthens the cycle, 8-bit modes given by both width codes, and back-to-back queuing.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
    localparam int DATA_W    = 16;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int ON_W      = 4;
    localparam int OFF_W     = 6;
    localparam int LEN_W     = 6;
    localparam int CNT_W     = 7;
    localparam int ADDR_W    = 3;
    localparam int REG_W     = 32;
    localparam int EDGE_W    = 3 * (ON_W + OFF_W);

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG   = 3'd0,
        RA_EDGE  = 3'd1,
        RA_CYC   = 3'd2,
        RA_CMD   = 3'd3,
        RA_PARAM = 3'd4,
        RA_READ  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        XK_WRITE = 1'b0,
        XK_READ  = 1'b1
    } xfer_kind_e;

    // packed MSB first so that cs_on lands in bits 3:0
    typedef struct packed {
        logic [OFF_W-1:0] re_off;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] we_off;
        logic [ON_W-1:0]  we_on;
        logic [OFF_W-1:0] cs_off;
        logic [ON_W-1:0]  cs_on;
    } edge_t;

    typedef struct packed {
        logic [LEN_W-1:0] acc;
        logic [LEN_W-1:0] cs_min;
        logic [LEN_W-1:0] rd_len;
        logic [LEN_W-1:0] wr_len;
    } cyc_t;

    typedef struct packed {
        xfer_kind_e        kind;
        logic              dc;
        logic [DATA_W-1:0] data;
    } xfer_t;

    function automatic logic [CNT_W-1:0] max2(input logic [CNT_W-1:0] a,
                                             input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // tick at which chip select releases, with the minimum pulse applied
    function automatic logic [CNT_W-1:0] cs_end(input edge_t e,
                                               input logic [LEN_W-1:0] min_w);
        return max2(CNT_W'(e.cs_off), CNT_W'(e.cs_on) + CNT_W'(min_w));
    endfunction

    function automatic logic [REG_W-1:0] cyc_word(input cyc_t c);
        return {4'b0, c.acc, 4'b0, c.cs_min, c.rd_len, c.wr_len};
    endfunction
endpackage

// File: rtl/lcdb_regs.sv
module lcdb_regs
    import lcdb_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_EDGE  = 32'h0C22_8941,
    parameter logic [REG_W-1:0] RST_CYC   = 32'h0200_4618,
    parameter bit               RST_DIV2  = 1'b1,
    parameter logic [1:0]       RST_WIDTH = 2'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [DATA_W-1:0] rd_sample,
    output logic [REG_W-1:0]  reg_rdata,
    output edge_t             edge_cfg,
    output cyc_t              cyc_cfg,
    output logic              div2,
    output logic              wide,
    output logic              req_v,
    output xfer_t             req
);
    localparam edge_t EDGE_INIT = edge_t'(RST_EDGE[EDGE_W-1:0]);
    localparam cyc_t  CYC_INIT  = '{acc: RST_CYC[27:22], cs_min: RST_CYC[17:12],
                                    rd_len: RST_CYC[11:6], wr_len: RST_CYC[5:0]};

    reg_addr_e  addr;
    logic [1:0] width_q;
    logic       unused_wbits;

    assign addr         = reg_addr_e'(reg_addr);
    assign wide         = (width_q == 2'b11);
    assign unused_wbits = ^reg_wdata[REG_W-1:EDGE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cfg  <= EDGE_INIT;
            cyc_cfg   <= CYC_INIT;
            div2      <= RST_DIV2;
            width_q   <= RST_WIDTH;
            reg_rdata <= '0;
        end else begin
            if (reg_wr) begin
                case (addr)
                    RA_CFG: begin
                        width_q <= reg_wdata[1:0];
                        div2    <= reg_wdata[4];
                    end
                    RA_EDGE: edge_cfg <= edge_t'(reg_wdata[EDGE_W-1:0]);
                    RA_CYC:  cyc_cfg  <= '{acc: reg_wdata[27:22], cs_min: reg_wdata[17:12],
                                           rd_len: reg_wdata[11:6], wr_len: reg_wdata[5:0]};
                    default: ;
                endcase
            end
            if (reg_rd) begin
                case (addr)
                    RA_CFG:  reg_rdata <= {27'b0, div2, 2'b0, width_q};
                    RA_EDGE: reg_rdata <= {{(REG_W-EDGE_W){1'b0}}, edge_cfg};
                    RA_CYC:  reg_rdata <= cyc_word(cyc_cfg);
                    RA_READ: reg_rdata <= {{(REG_W-DATA_W){1'b0}}, rd_sample};
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    always_comb begin
        req_v     = reg_wr && (addr == RA_CMD || addr == RA_PARAM || addr == RA_READ);
        req.kind  = (addr == RA_READ) ? XK_READ : XK_WRITE;
        req.dc    = (addr != RA_CMD);
        req.data  = reg_wdata[DATA_W-1:0];
    end
endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
    import lcdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  edge_t             edge_cfg,
    input  cyc_t              cyc_cfg,
    input  logic              div2,
    input  logic              wide,
    input  logic              in_v,
    input  xfer_t             in_x,
    input  logic [DATA_W-1:0] din,
    output logic              in_ready,
    output logic              active,
    output logic [CNT_W-1:0]  cnt,
    output xfer_t             cur_q,
    output edge_t             e_q,
    output logic [LEN_W-1:0]  csmin_q,
    output logic              wide_q,
    output logic [DATA_W-1:0] rd_q
);
    logic             pend_v, ph, div2_q, start, tick_last;
    xfer_t            pend_q;
    logic [LEN_W-1:0] acc_q, len;
    logic [CNT_W-1:0] end_q, start_end;

    assign in_ready  = !pend_v;
    assign start     = !active && pend_v;
    assign tick_last = !div2_q || ph;

    always_comb begin
        len       = (pend_q.kind == XK_READ) ? cyc_cfg.rd_len : cyc_cfg.wr_len;
        start_end = max2(CNT_W'(len), cs_end(edge_cfg, cyc_cfg.cs_min));
        if (start_end == '0) start_end = CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v  <= 1'b0;
            pend_q  <= '{kind: XK_WRITE, dc: 1'b1, data: '0};
            active  <= 1'b0;
            cnt     <= '0;
            ph      <= 1'b0;
            cur_q   <= '{kind: XK_WRITE, dc: 1'b1, data: '0};
            e_q     <= '0;
            csmin_q <= '0;
            acc_q   <= '0;
            end_q   <= CNT_W'(1);
            div2_q  <= 1'b0;
            wide_q  <= 1'b1;
            rd_q    <= '0;
        end else begin
            if (in_v && !pend_v) begin
                pend_v <= 1'b1;
                pend_q <= in_x;
            end else if (start) begin
                pend_v <= 1'b0;
            end

            if (start) begin
                active  <= 1'b1;
                cnt     <= '0;
                ph      <= 1'b0;
                cur_q   <= pend_q;
                e_q     <= edge_cfg;
                csmin_q <= cyc_cfg.cs_min;
                acc_q   <= cyc_cfg.acc;
                end_q   <= start_end;
                div2_q  <= div2;
                wide_q  <= wide;
            end else if (active) begin
                if (tick_last) begin
                    ph <= 1'b0;
                    if (cnt == end_q - CNT_W'(1)) active <= 1'b0;
                    else                          cnt    <= cnt + CNT_W'(1);
                end else begin
                    ph <= 1'b1;
                end
            end

            if (active && cur_q.kind == XK_READ && cnt == CNT_W'(acc_q) && !ph)
                rd_q <= wide_q ? din : {{(DATA_W-LANE_W){1'b0}}, din[LANE_W-1:0]};
        end
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && active) |=> (pend_v && $stable(pend_q)));
    // R10
    slot_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && pend_v) |=> (active && !pend_v));
    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < end_q));
    // R4
    div1_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !div2_q) |-> !ph);
endmodule

// File: rtl/lcdb_strobe.sv
module lcdb_strobe
    import lcdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt,
    input  xfer_t             cur,
    input  edge_t             e,
    input  logic [LEN_W-1:0]  csmin,
    input  logic              wide,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dc,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);
    logic             is_wr, in_cs, in_we, in_re;
    logic [NUM_LANES-1:0] lane_en;

    always_comb begin
        is_wr = (cur.kind == XK_WRITE);
        in_cs = (cnt >= CNT_W'(e.cs_on)) && (cnt < cs_end(e, csmin));
        in_we = (cnt >= CNT_W'(e.we_on)) && (cnt < CNT_W'(e.we_off));
        in_re = (cnt >= CNT_W'(e.re_on)) && (cnt < CNT_W'(e.re_off));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
            re_n <= 1'b1;
            dc   <= 1'b1;
            doe  <= 1'b0;
        end else begin
            cs_n <= !(active && in_cs);
            we_n <= !(active && is_wr && in_we);
            re_n <= !(active && !is_wr && in_re);
            doe  <= active && is_wr;
            if (active) dc <= cur.dc;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            assign lane_en[g] = 1'b1;
        end else begin : g_upper
            assign lane_en[g] = wide;
        end
        always_ff @(posedge clk) begin
            if (rst)
                dout[g*LANE_W +: LANE_W] <= '0;
            else if (active && is_wr)
                dout[g*LANE_W +: LANE_W] <= lane_en[g] ? cur.data[g*LANE_W +: LANE_W] : '0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |=> (cs_n && we_n && re_n));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> re_n);
    // R8
    doe_read_chk: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !doe);
endmodule

// File: rtl/lcdb_bus_gen.sv
module lcdb_bus_gen
    import lcdb_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_EDGE  = 32'h0C22_8941,
    parameter logic [REG_W-1:0] RST_CYC   = 32'h0200_4618,
    parameter bit               RST_DIV2  = 1'b1,
    parameter logic [1:0]       RST_WIDTH = 2'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              req_ready,
    output logic              busy,
    output logic              lcd_cs_n,
    output logic              lcd_we_n,
    output logic              lcd_re_n,
    output logic              lcd_dc,
    output logic [DATA_W-1:0] lcd_dout,
    output logic              lcd_doe,
    input  logic [DATA_W-1:0] lcd_din
);
    edge_t             edge_cfg, e_q;
    cyc_t              cyc_cfg;
    logic              div2, wide, req_v, in_v, active, wide_q;
    xfer_t             req, in_x, cur_q;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  csmin_q;
    logic [DATA_W-1:0] rd_q;

    assign push_ready = req_ready && !req_v;
    assign in_v       = req_v || push_valid;
    assign in_x       = req_v ? req : '{kind: XK_WRITE, dc: 1'b1, data: push_data};
    assign busy       = active;

    lcdb_regs #(
        .RST_EDGE (RST_EDGE),
        .RST_CYC  (RST_CYC),
        .RST_DIV2 (RST_DIV2),
        .RST_WIDTH(RST_WIDTH)
    ) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_sample(rd_q),
        .reg_rdata(reg_rdata), .edge_cfg(edge_cfg), .cyc_cfg(cyc_cfg),
        .div2(div2), .wide(wide), .req_v(req_v), .req(req)
    );

    lcdb_seq seq_i (
        .clk(clk), .rst(rst), .edge_cfg(edge_cfg), .cyc_cfg(cyc_cfg),
        .div2(div2), .wide(wide), .in_v(in_v), .in_x(in_x), .din(lcd_din),
        .in_ready(req_ready), .active(active), .cnt(cnt), .cur_q(cur_q),
        .e_q(e_q), .csmin_q(csmin_q), .wide_q(wide_q), .rd_q(rd_q)
    );

    lcdb_strobe strobe_i (
        .clk(clk), .rst(rst), .active(active), .cnt(cnt), .cur(cur_q),
        .e(e_q), .csmin(csmin_q), .wide(wide_q),
        .cs_n(lcd_cs_n), .we_n(lcd_we_n), .re_n(lcd_re_n), .dc(lcd_dc),
        .dout(lcd_dout), .doe(lcd_doe)
    );
endmodule

// File: tb/lcdb_bus_gen_tb_top.sv
module lcdb_bus_gen_tb_top;
    import lcdb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        push_valid = 1'b0;
    logic [15:0] push_data = '0;
    logic        push_ready, req_ready, busy;
    logic        lcd_cs_n, lcd_we_n, lcd_re_n, lcd_dc, lcd_doe;
    logic [15:0] lcd_dout;
    logic [15:0] lcd_din = '0;

    always #2 clk = ~clk;

    lcdb_bus_gen dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .req_ready(req_ready), .busy(busy), .lcd_cs_n(lcd_cs_n),
        .lcd_we_n(lcd_we_n), .lcd_re_n(lcd_re_n), .lcd_dc(lcd_dc),
        .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
    );

    typedef struct {
        bit rd; bit dc; int data;
        int cs_first; int cs_cnt; int st_first; int st_cnt; int blen;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0, n_fail = 0, n_done = 0;
    bit done = 0;

    // shadow of the programmed settings
    int s_div2 = 1, s_wide = 1;
    int cs_on = 1, cs_off = 20, we_on = 2, we_off = 10, re_on = 2, re_off = 12;
    int wr_len = 24, rd_len = 24, cs_min = 4, acc = 8;

    task automatic chk_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    function automatic exp_t mk(bit rd, bit dc, int data);
        exp_t x;
        int d, csend, len, e;
        d     = s_div2 ? 2 : 1;
        csend = (cs_off > cs_on + cs_min) ? cs_off : cs_on + cs_min;
        len   = rd ? rd_len : wr_len;
        e     = (len > csend) ? len : csend;
        if (e == 0) e = 1;
        x.rd = rd; x.dc = dc;
        x.data     = s_wide ? (data & 32'hFFFF) : (data & 32'hFF);
        x.cs_first = cs_on * d + 1;
        x.cs_cnt   = (csend - cs_on) * d;
        x.st_first = (rd ? re_on : we_on) * d + 1;
        x.st_cnt   = (rd ? (re_off - re_on) : (we_off - we_on)) * d;
        x.blen     = e * d;
        return x;
    endfunction

    task automatic reg_write(int a, int v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int a, output int v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    // driver: waits for a free slot, issues, and records the expected cycle
    task automatic issue(int a, int v);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = v;
        sb.push_back(mk(a == 5, a != 3, v));
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(int v);
        @(negedge clk);
        while (!push_ready) @(negedge clk);
        push_valid = 1'b1; push_data = 16'(v);
        sb.push_back(mk(0, 1, v));
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic set_edge(int a0, int a1, int b0, int b1, int c0, int c1);
        cs_on = a0; cs_off = a1; we_on = b0; we_off = b1; re_on = c0; re_off = c1;
        reg_write(1, a0 | (a1 << 4) | (b0 << 10) | (b1 << 14) | (c0 << 20) | (c1 << 24));
    endtask

    task automatic set_cyc(int w, int r, int m, int s);
        wr_len = w; rd_len = r; cs_min = m; acc = s;
        reg_write(2, w | (r << 6) | (m << 12) | (s << 22));
    endtask

    task automatic set_cfg(int v);
        s_div2 = (v >> 4) & 1; s_wide = ((v & 3) == 3);
        reg_write(0, v);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || !req_ready || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: rebuilds each cycle from the pins and compares with the queue
    int kk = 0;
    bit in_cyc = 0;
    int o_csf, o_csc, o_stf, o_stc, o_dc, o_data;
    bit o_rd;

    task automatic mon_sample(int idx);
        if (!lcd_cs_n) begin
            if (o_csc == 0) o_csf = idx;
            o_csc++;
        end
        if (!lcd_we_n || !lcd_re_n) begin
            if (o_stc == 0) begin
                o_stf = idx; o_rd = !lcd_re_n; o_dc = lcd_dc; o_data = lcd_dout;
            end
            o_stc++;
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                if (!in_cyc) begin
                    kk = 0; o_csc = 0; o_stc = 0; o_csf = -1; o_stf = -1;
                    o_rd = 0; o_dc = 0; o_data = 0;
                end else begin
                    kk = kk + 1;
                end
                in_cyc = 1;
                if (kk >= 1) mon_sample(kk);
                lcd_din = 16'h5A00 ^ 16'(kk);
            end else if (in_cyc) begin
                mon_sample(kk + 1);
                in_cyc = 0;
                n_done++;
                if (sb.size() == 0) begin
                    chk_eq("R10 unexpected bus cycle", 1, 0);
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk_eq("R7 busy length", kk + 1, x.blen);
                    chk_eq("R7 cs first low clock", o_csf, x.cs_first);
                    chk_eq("R7 cs low clocks", o_csc, x.cs_cnt);
                    chk_eq(x.rd ? "R8 re first low clock" : "R6 we first low clock", o_stf, x.st_first);
                    chk_eq(x.rd ? "R8 re low clocks" : "R6 we low clocks", o_stc, x.st_cnt);
                    chk_eq("R8 strobe kind", int'(o_rd), int'(x.rd));
                    if (!x.rd) begin
                        chk_eq("R5 dc level", o_dc, int'(x.dc));
                        chk_eq("R9 driven data", o_data, x.data);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog act=hung exp=finished");
        report();
        $finish;
    end

    initial begin
        int v, base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 cs_n", lcd_cs_n, 1);
        chk_eq("R1 we_n", lcd_we_n, 1);
        chk_eq("R1 re_n", lcd_re_n, 1);
        chk_eq("R1 doe", lcd_doe, 0);
        chk_eq("R1 dc", lcd_dc, 1);
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 req_ready", req_ready, 1);
        reg_read(0, v); chk_eq("R1 cfg reset", v, 32'h13);
        reg_read(1, v); chk_eq("R1 edge reset", v, 32'h0C22_8941);
        reg_read(2, v); chk_eq("R1 cycle reset", v, 32'h0200_4618);

        // R4 R5 R6 default two-clock tick
        issue(3, 32'h1234);
        wait_idle();
        issue(4, 32'hBEEF);
        wait_idle();

        // R4 one-clock tick, R2 R3 readback
        set_cfg(32'h03);
        set_edge(0, 6, 1, 4, 1, 5);
        set_cyc(8, 7, 3, 3);
        reg_read(1, v); chk_eq("R2 edge readback", v, 0 | (6 << 4) | (1 << 10) | (4 << 14) | (1 << 20) | (5 << 24));
        reg_read(2, v); chk_eq("R3 cycle readback", v, 8 | (7 << 6) | (3 << 12) | (3 << 22));
        reg_write(2, 32'hFFFF_FFFF);
        reg_read(2, v); chk_eq("R3 unused bits zero", v, 32'h0FC3_FFFF);
        set_cyc(8, 7, 3, 3);
        issue(3, 32'h00A5);
        wait_idle();

        // R7 minimum chip-select pulse stretches the cycle
        set_cyc(8, 7, 10, 3);
        issue(4, 32'h7E81);
        wait_idle();

        // R8 read cycle and sample readback
        issue(5, 0);
        wait_idle();
        reg_read(5, v); chk_eq("R8 read sample", v, 32'h5A03);

        // R9 8-bit mode, two-clock tick
        set_cfg(32'h10);
        issue(4, 32'hABCD);
        wait_idle();
        issue(5, 0);
        wait_idle();
        reg_read(5, v); chk_eq("R9 8-bit read sample", v, (32'h5A00 ^ 6) & 32'hFF);
        set_cfg(32'h12);
        reg_read(0, v); chk_eq("R9 width field readback", v, 32'h12);
        issue(3, 32'h1357);
        wait_idle();

        // R10 queuing and ignored request
        set_cfg(32'h03);
        base = n_done;
        issue(3, 32'h0011);
        issue(4, 32'h0022);
        @(negedge clk);
        chk_eq("R10 slot full", req_ready, 0);
        reg_write(4, 32'h0033);
        wait_idle();
        chk_eq("R10 cycles after ignored request", n_done - base, 2);

        // R11 pixel push path
        base = n_done;
        push(32'h4242);
        push(32'h4343);
        wait_idle();
        chk_eq("R11 pushed cycles", n_done - base, 2);

        // R11 register write wins over push in the same clock
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0099;
        push_valid = 1'b1; push_data = 16'h7777;
        sb.push_back(mk(0, 0, 32'h0099));
        #1 chk_eq("R11 push_ready with register write", push_ready, 0);
        @(negedge clk);
        reg_wr = 1'b0; push_valid = 1'b0;
        wait_idle();

        chk_eq("R10 scoreboard drained", sb.size(), 0);
        report();
        $finish;
    end
endmodule